// File: doc/BRIEF.md
# DE-Gap Sync Regenerator

This block rebuilds line and frame timing for a pixel stream that carries only a data-enable flag and pixel words, with no sync pins of its own. It watches how long the data-enable flag stays low. A blanking run that reaches the programmed line gap yields a line sync pulse. A run that reaches the longer frame gap also yields a frame sync pulse. The frames downstream therefore keep their order even though the source never marks them.

Pixels pass through one register stage, so data-enable, pixel data and the new syncs leave the block aligned with one another. The stream is paced by the pixel clock and has no back-pressure: every clock carries one pixel, and the block neither stalls nor drops any. The two gap lengths are taken into use only on pixels where data-enable is high. A setting changed during blanking therefore first applies to the next blanking run. A gap pair that breaks the ordering rule raises a configuration error and stops all sync generation.

Top module: `dgs_sync_regen`

## Requirements
- R1: While reset is held, `out_de`, `out_hsync`, `out_vsync` and `out_sof` are 0. With the reset gap pair (line 4, frame 16), `cfg_err` is 0.
- R2: Each output pixel repeats the input `in_de` and `in_data` of the pixel one clock earlier, whatever the setting of `en` or `cfg_err`.
- R3: The run counter returns to zero on every pixel with `in_de` high and holds at 2^CW-1 when it saturates. A frame gap set to 2^CW-1 still fires exactly once in a run longer than that.
- R4: `out_hsync` goes high for one clock, on the output pixel that is the N-th consecutive low-DE pixel, where N is the line gap in use.
- R5: `out_vsync` goes high for one clock, on the output pixel that is the M-th consecutive low-DE pixel, where M is the frame gap in use.
- R6: A single blanking run yields at most one `out_hsync` and at most one `out_vsync`, however long the run lasts.
- R7: `cfg_err` is 1 whenever the gap pair in use has a line gap of 1 or less, or a line gap not below the frame gap. While it is 1, no sync and no start-of-frame is produced.
- R8: `out_sof` is high for one clock, on the first DE-high output pixel that follows an `out_vsync`, and at no other time.
- R9: Gap inputs are taken into use only at clocks where `in_de` is high. A change made during a blanking run does not alter the syncs of that run.
- R10: With `en` low, no sync and no start-of-frame is produced, and a pending start-of-frame is dropped.
- R11: A blanking run shorter than the line gap produces no sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sync generation enable |
| in_de | input | 1 | Input data-enable |
| in_data | input | DW | Input pixel word |
| hgap_len | input | CW | Line gap length, in low-DE pixels |
| vgap_len | input | CW | Frame gap length, in low-DE pixels |
| out_de | output | 1 | Delayed data-enable |
| out_data | output | DW | Delayed pixel word |
| out_hsync | output | 1 | Generated line sync, active high |
| out_vsync | output | 1 | Generated frame sync, active high |
| out_sof | output | 1 | First active pixel of a frame |
| cfg_err | output | 1 | Gap pair breaks the ordering rule |

## Verification
The bench drives several kinds of blanking run: one shorter than the line gap, one between the two gaps, and one past the frame gap. Together these separate the no-sync, line-only and line-plus-frame outcomes, and each sync's position within the run is checked. A run far longer than a saturating frame gap shows whether saturation repeats a pulse. Gap values rewritten in mid-blanking show whether the new values take effect too early. Illegal gap pairs and a disabled block are each followed by a full frame-length run and a line, to prove that no pulse and no start-of-frame leak through.

// File: rtl/dgs_pkg.sv
package dgs_pkg;
  // one-clock sync requests raised by the pulse generator
  typedef struct packed {
    logic hs;
    logic vs;
  } dgs_fire_t;
endpackage

// File: rtl/dgs_gap_counter.sv
module dgs_gap_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de,
  output logic [CW-1:0] run_len
);
  localparam logic [CW-1:0] SAT = '1;
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_len <= '0;
    else if (de)              run_len <= '0;
    else if (run_len != SAT)  run_len <= run_len + ONE;
  end

  // the run length never falls inside a blanking run
  p_run_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !de |=> run_len >= $past(run_len));
endmodule

// File: rtl/dgs_gap_cfg.sv
module dgs_gap_cfg #(
  parameter int CW       = 12,
  parameter int HGAP_RST = 4,
  parameter int VGAP_RST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de,
  input  logic [CW-1:0] hgap_in,
  input  logic [CW-1:0] vgap_in,
  output logic [CW-1:0] hthr,
  output logic [CW-1:0] vthr,
  output logic          cfg_bad
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // gap pair is only refreshed on active pixels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hthr <= CW'(HGAP_RST);
      vthr <= CW'(VGAP_RST);
    end else if (de) begin
      hthr <= hgap_in;
      vthr <= vgap_in;
    end
  end

  assign cfg_bad = !((hthr > ONE) && (hthr < vthr));

  p_thr_hold_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !de |=> ($stable(hthr) && $stable(vthr)));
endmodule

// File: rtl/dgs_sync_gen.sv
module dgs_sync_gen
  import dgs_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cfg_bad,
  input  logic          de,
  input  logic [CW-1:0] run_len,
  input  logic [CW-1:0] hthr,
  input  logic [CW-1:0] vthr,
  output logic          hs,
  output logic          vs,
  output logic          sof
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic      allow;
  logic      armed;
  dgs_fire_t fire;

  assign allow = en && !cfg_bad;

  // compare with the previous count: hit once per run, even when saturated
  always_comb begin
    fire.hs = allow && !de && (run_len == hthr - ONE);
    fire.vs = allow && !de && (run_len == vthr - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs    <= 1'b0;
      vs    <= 1'b0;
      sof   <= 1'b0;
      armed <= 1'b0;
    end else begin
      hs  <= fire.hs;
      vs  <= fire.vs;
      sof <= allow && de && armed;
      if (!allow)       armed <= 1'b0;
      else if (fire.vs) armed <= 1'b1;
      else if (de)      armed <= 1'b0;
    end
  end

  p_hs_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> !hs);
  p_vs_one_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vs |=> !vs);
  p_sof_one_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |=> (!hs && !vs && !sof));
endmodule

// File: rtl/dgs_sync_regen.sv
module dgs_sync_regen #(
  parameter int DW       = 24,
  parameter int CW       = 12,
  parameter int HGAP_RST = 4,
  parameter int VGAP_RST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_de,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] hgap_len,
  input  logic [CW-1:0] vgap_len,
  output logic          out_de,
  output logic [DW-1:0] out_data,
  output logic          out_hsync,
  output logic          out_vsync,
  output logic          out_sof,
  output logic          cfg_err
);
  logic [CW-1:0] run_len;
  logic [CW-1:0] hthr;
  logic [CW-1:0] vthr;

  dgs_gap_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .de(in_de), .run_len(run_len)
  );

  dgs_gap_cfg #(.CW(CW), .HGAP_RST(HGAP_RST), .VGAP_RST(VGAP_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .de(in_de),
    .hgap_in(hgap_len), .vgap_in(vgap_len),
    .hthr(hthr), .vthr(vthr), .cfg_bad(cfg_err)
  );

  dgs_sync_gen #(.CW(CW)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_bad(cfg_err), .de(in_de),
    .run_len(run_len), .hthr(hthr), .vthr(vthr),
    .hs(out_hsync), .vs(out_vsync), .sof(out_sof)
  );

  // pixel path: one stage, aligned with the sync registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_de   <= 1'b0;
      out_data <= '0;
    end else begin
      out_de   <= in_de;
      out_data <= in_data;
    end
  end

  p_sync_in_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hsync || out_vsync) |-> !out_de);
  p_sof_with_de_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_de);
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_hsync && !out_vsync && !out_sof));
  p_de_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_de |=> out_de);
endmodule

// File: tb/dgs_sync_regen_tb.sv
module dgs_sync_regen_tb;
  localparam int DW = 24;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic          in_de = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] hgap_len = CW'(3);
  logic [CW-1:0] vgap_len = CW'(10);
  logic          out_de, out_hsync, out_vsync, out_sof, cfg_err;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dgs_sync_regen #(.DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .in_de(in_de), .in_data(in_data),
    .hgap_len(hgap_len), .vgap_len(vgap_len),
    .out_de(out_de), .out_data(out_data), .out_hsync(out_hsync),
    .out_vsync(out_vsync), .out_sof(out_sof), .cfg_err(cfg_err)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one pixel: drive on the falling edge, sample just after the rising edge
  task automatic step(bit de, logic [DW-1:0] d);
    @(negedge clk);
    in_de   = de;
    in_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic gap(int n, int exp_h, int exp_v, string req);
    int hc = 0, vc = 0, hp = 0, vp = 0, sc = 0;
    for (int i = 1; i <= n; i++) begin
      step(1'b0, DW'(i));
      if (out_hsync) begin hc++; hp = i; end
      if (out_vsync) begin vc++; vp = i; end
      if (out_sof) sc++;
    end
    chk(hc == (exp_h != 0 ? 1 : 0), req, "hsync count", hc, exp_h != 0 ? 1 : 0);
    chk(hp == exp_h, req, "hsync position", hp, exp_h);
    chk(vc == (exp_v != 0 ? 1 : 0), req, "vsync count", vc, exp_v != 0 ? 1 : 0);
    chk(vp == exp_v, req, "vsync position", vp, exp_v);
    chk(sc == 0, "R8", "sof during blanking", sc, 0);
  endtask

  task automatic line(int len, bit exp_sof, string req);
    int bad = 0, sc = 0, first = 0;
    for (int i = 0; i < len; i++) begin
      logic [DW-1:0] d;
      d = DW'(32'hA50000 + i * 7 + len);
      step(1'b1, d);
      if (out_de !== 1'b1 || out_data !== d) bad++;
      if (out_sof) begin sc++; if (i == 0) first = 1; end
    end
    chk(bad == 0, "R2", "pixel pass-through mismatches", bad, 0);
    chk(sc == (exp_sof ? 1 : 0), req, "sof count", sc, exp_sof ? 1 : 0);
    chk(first == (exp_sof ? 1 : 0), req, "sof on first pixel", first, exp_sof ? 1 : 0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(out_de == 0 && out_hsync == 0 && out_vsync == 0 && out_sof == 0,
        "R1", "outputs in reset", int'({out_de, out_hsync, out_vsync, out_sof}), 0);
    chk(cfg_err == 0, "R1", "cfg_err with reset gaps", int'(cfg_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_short();
    line(8, 1'b0, "R2");
    gap(2, 0, 0, "R11");
    line(4, 1'b0, "R11");
  endtask

  task automatic t_line_only();
    gap(5, 3, 0, "R4");
    line(4, 1'b0, "R8");
  endtask

  task automatic t_frame();
    gap(12, 3, 10, "R5");
    line(4, 1'b1, "R8");
  endtask

  task automatic t_saturate();
    vgap_len = CW'(4095);
    line(2, 1'b0, "R3");
    gap(5000, 3, 4095, "R3");
    line(2, 1'b1, "R6");
  endtask

  task automatic t_midgap();
    vgap_len = CW'(10);
    line(2, 1'b0, "R9");
    hgap_len = CW'(2);
    vgap_len = CW'(6);
    gap(12, 3, 10, "R9");
    line(2, 1'b1, "R9");
    gap(8, 2, 6, "R9");
    line(2, 1'b1, "R9");
  endtask

  task automatic t_cfg_err();
    hgap_len = CW'(1);
    vgap_len = CW'(10);
    line(2, 1'b0, "R7");
    chk(cfg_err == 1, "R7", "cfg_err line gap 1", int'(cfg_err), 1);
    gap(20, 0, 0, "R7");
    line(2, 1'b0, "R7");
    hgap_len = CW'(8);
    vgap_len = CW'(8);
    line(2, 1'b0, "R7");
    chk(cfg_err == 1, "R7", "cfg_err equal gaps", int'(cfg_err), 1);
    gap(20, 0, 0, "R7");
    hgap_len = CW'(3);
    vgap_len = CW'(10);
    line(2, 1'b0, "R7");
    chk(cfg_err == 0, "R7", "cfg_err legal pair", int'(cfg_err), 0);
  endtask

  task automatic t_disabled();
    en = 1'b0;
    gap(12, 0, 0, "R10");
    line(3, 1'b0, "R10");
    en = 1'b1;
    gap(12, 3, 10, "R10");
    line(2, 1'b1, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_short();
    t_line_only();
    t_frame();
    t_saturate();
    t_midgap();
    t_cfg_err();
    t_disabled();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule